// File: doc/BRIEF.md
# Weight-Stationary Matrix Multiply Engine

This block multiplies a stream of input rows by a square weight matrix that is held constant for a whole operation. The weights are written first, one matrix row per beat, while the engine is idle. A start command then gives a row count B, a base address in an on-block accumulator bank and three mode bits: the signedness of the input operands, the signedness of the weights, and whether results overwrite or add to the rows already stored. The engine accepts B input rows of N 8-bit elements on a valid/ready stream. It delivers one result row of N 32-bit sums per accepted row, and once its short pipeline has filled it keeps up with one row per clock.

Result row k is stored at accumulator address base+k, and the address wraps at the bank depth. In accumulate mode, partial sums from several weight tiles can be combined in the same rows. A separate read port returns one stored row per request, one cycle after the request. A single-cycle completion pulse marks the end of each operation.

The control is a four-state machine. `ST_IDLE` accepts weight beats and start commands; IDLE to RUN happens on a start with a non-zero row count. `ST_RUN` accepts input rows; RUN to DRAIN happens when the last of the B rows is taken. `ST_DRAIN` waits until the two pipeline stages are empty; DRAIN to DONE happens once the last result has been written. `ST_DONE` lasts one cycle and raises the completion pulse; DONE to IDLE is unconditional.

Top module: `wsmm_engine`

## Requirements
- R1: In ST_IDLE, `w_ready` is high. Each accepted weight beat stores weight row j, where j is 0 for the first beat after reset and advances by one per beat, wrapping to 0 after N beats. Element (j,c) sits at `w_row` bits [8c+7:8c] of beat j.
- R2: From the cycle after a start is accepted until the engine returns to ST_IDLE, `w_ready` is low, and weight beats offered in that time leave the weights unchanged.
- R3: Column c of result row k equals the sum over j of x_k[j]·W[j][c]. Input element j is `x_row` bits [8j+7:8j]; result column c is `rd_data` bits [32c+31:32c].
- R4: Each operand is sign-extended when its mode bit (`start_x_signed`, `start_w_signed`) is 1 and zero-extended when it is 0. The modes are captured at start and apply to the whole operation.
- R5: With `start_accum`=0, a result replaces the stored row. With 1, it is added to the stored row column by column, modulo 2^32 and without saturation.
- R6: Result row k is written to address (start_base + k) mod DEPTH.
- R7: With `x_valid` held high, `x_ready` is high for exactly B consecutive cycles starting the cycle after the start edge. `done` is high in the cycle that follows the (B+3)-th rising edge after the start edge.
- R8: When `x_valid` is low in some cycles, the stream stalls without losing or duplicating a row, and the stored results equal those of an unbroken stream.
- R9: `done` is a one-cycle pulse that comes after the last result write, so a read issued while `done` is high returns the final data.
- R10: With `rd_en` high, `rd_data` shows the row at `rd_addr` in the following cycle. With `rd_en` low, `rd_data` holds its value.
- R11: A start offered while not in ST_IDLE, or carrying a row count of 0, is ignored: no writes occur and no `done` pulse follows.
- R12: After reset, every accumulator row reads as zero, `w_ready` is high, and `x_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_valid | input | 1 | Weight beat offered |
| w_ready | output | 1 | Weight beat accepted (idle only) |
| w_row | input | N*8 | One weight matrix row |
| start | input | 1 | Start command |
| start_base | input | log2(DEPTH) | First accumulator address |
| start_rows | input | CNT_W | Row count B |
| start_accum | input | 1 | 1 = add to stored rows, 0 = overwrite |
| start_x_signed | input | 1 | Input elements are signed |
| start_w_signed | input | 1 | Weights are signed |
| x_valid | input | 1 | Input row offered |
| x_ready | output | 1 | Input row accepted |
| x_row | input | N*8 | Input row |
| done | output | 1 | Operation complete pulse |
| rd_en | input | 1 | Read request |
| rd_addr | input | log2(DEPTH) | Read address |
| rd_data | output | N*32 | Row read, one cycle after the request |

## Verification
A wrong row counter or a wrong state change shows at the ports within one operation. `x_ready` stays open for more or fewer than B cycles, or `done` arrives at a cycle other than B+3 edges after start. A corrupted weight pointer or a pipeline that loses a stalled row only shows when the accumulator rows are read back after `done`, so every operation is followed by reading each touched row. Errors in the accumulate path or in signedness can hide behind small positive values. Mixed-sign operands and a sum that goes below zero expose them in the first row written.

// File: rtl/wsmm_pkg.sv
package wsmm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } wsmm_state_e;

    typedef struct packed {
        logic accum;
        logic x_sgn;
        logic w_sgn;
    } wsmm_mode_t;

endpackage

// File: rtl/wsmm_weight_bank.sv
module wsmm_weight_bank #(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [N*DW-1:0]   row_in,
    output logic [N*N*DW-1:0] w_flat
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr;
    logic [N*DW-1:0]  w_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int j = 0; j < N; j++) w_q[j] <= '0;
        end else if (load) begin
            w_q[ptr] <= row_in;
            ptr      <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_row
        assign w_flat[j*N*DW +: N*DW] = w_q[j];
    end

    // R2: no weight row is written while an operation is in progress
    a_r2_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/wsmm_dot_col.sv
module wsmm_dot_col #(
    parameter int N     = 4,
    parameter int DW    = 8,
    parameter int ACC_W = 32
) (
    input  logic [N*DW-1:0]  x_row,
    input  logic [N*DW-1:0]  w_col,
    input  logic             x_sgn,
    input  logic             w_sgn,
    output logic [ACC_W-1:0] sum
);
    localparam int EW = DW + 1;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] xe;
    logic signed [EW-1:0] we;
    logic signed [PW-1:0] p;

    always_comb begin
        sum = '0;
        xe  = '0;
        we  = '0;
        p   = '0;
        for (int j = 0; j < N; j++) begin
            xe  = signed'({x_sgn & x_row[j*DW+DW-1], x_row[j*DW +: DW]});
            we  = signed'({w_sgn & w_col[j*DW+DW-1], w_col[j*DW +: DW]});
            p   = xe * we;
            sum = sum + {{(ACC_W-PW){p[PW-1]}}, p};
        end
    end

endmodule

// File: rtl/wsmm_acc_bank.sv
module wsmm_acc_bank #(
    parameter int N      = 4,
    parameter int ACC_W  = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_add,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [N*ACC_W-1:0]  wr_row,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [N*ACC_W-1:0]  rd_data
);
    logic [N*ACC_W-1:0] mem [DEPTH];
    logic [N*ACC_W-1:0] old_row;
    logic [N*ACC_W-1:0] merged;

    assign old_row = mem[wr_addr];

    for (genvar c = 0; c < N; c++) begin : g_col
        assign merged[c*ACC_W +: ACC_W] = wr_add
            ? old_row[c*ACC_W +: ACC_W] + wr_row[c*ACC_W +: ACC_W]
            : wr_row[c*ACC_W +: ACC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) mem[wr_addr] <= merged;
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end

    // R10: the read register holds when no read is requested
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/wsmm_engine.sv
module wsmm_engine #(
    parameter int N     = 4,
    parameter int DW    = 8,
    parameter int ACC_W = 32,
    parameter int DEPTH = 16,
    parameter int CNT_W = 8,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int ROW_W  = N * DW,
    localparam int OUT_W  = N * ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [ROW_W-1:0]  w_row,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [CNT_W-1:0]  start_rows,
    input  logic              start_accum,
    input  logic              start_x_signed,
    input  logic              start_w_signed,
    input  logic              x_valid,
    output logic              x_ready,
    input  logic [ROW_W-1:0]  x_row,
    output logic              done,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [OUT_W-1:0]  rd_data
);
    import wsmm_pkg::*;

    localparam int SUM_W = (CNT_W > ADDR_W) ? CNT_W : ADDR_W;

    wsmm_state_e state, nxt;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  rows_q;
    logic [CNT_W-1:0]  in_cnt;
    wsmm_mode_t        mode_q;

    logic              v1, v2;
    logic [ROW_W-1:0]  x1;
    logic [ADDR_W-1:0] addr1, addr2;
    logic [OUT_W-1:0]  sums, s2;
    logic [ROW_W*N-1:0] w_flat;
    logic [SUM_W-1:0]  addr_full;

    logic start_ok, x_fire, last_in, pipe_empty;

    assign start_ok   = (state == ST_IDLE) && start && (start_rows != '0);
    assign x_fire     = x_valid && x_ready;
    assign last_in    = x_fire && (in_cnt == rows_q - 1'b1);
    assign pipe_empty = !v1 && !v2;
    assign addr_full  = SUM_W'(base_q) + SUM_W'(in_cnt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_ok)   nxt = ST_RUN;
            ST_RUN:   if (last_in)    nxt = ST_DRAIN;
            ST_DRAIN: if (pipe_empty) nxt = ST_DONE;
            ST_DONE:                  nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        w_ready = 1'b0;
        x_ready = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:  w_ready = 1'b1;
            ST_RUN:   x_ready = 1'b1;
            ST_DRAIN: ;
            ST_DONE:  done    = 1'b1;
            default:  ;
        endcase
    end

    // command capture, row counting and pipeline stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            rows_q <= '0;
            in_cnt <= '0;
            mode_q <= '0;
            v1     <= 1'b0;
            v2     <= 1'b0;
            x1     <= '0;
            addr1  <= '0;
            addr2  <= '0;
            s2     <= '0;
        end else begin
            if (start_ok) begin
                base_q <= start_base;
                rows_q <= start_rows;
                in_cnt <= '0;
                mode_q <= '{accum: start_accum, x_sgn: start_x_signed,
                            w_sgn: start_w_signed};
            end
            if (x_fire) begin
                x1     <= x_row;
                addr1  <= addr_full[ADDR_W-1:0];
                in_cnt <= in_cnt + 1'b1;
            end
            v1    <= x_fire;
            v2    <= v1;
            s2    <= sums;
            addr2 <= addr1;
        end
    end

    wsmm_weight_bank #(.N(N), .DW(DW)) u_wbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (w_valid && w_ready),
        .busy   (state != ST_IDLE),
        .row_in (w_row),
        .w_flat (w_flat)
    );

    for (genvar c = 0; c < N; c++) begin : g_col
        logic [ROW_W-1:0] wcol;
        for (genvar j = 0; j < N; j++) begin : g_tap
            assign wcol[j*DW +: DW] = w_flat[(j*N + c)*DW +: DW];
        end
        wsmm_dot_col #(.N(N), .DW(DW), .ACC_W(ACC_W)) u_dot (
            .x_row (x1),
            .w_col (wcol),
            .x_sgn (mode_q.x_sgn),
            .w_sgn (mode_q.w_sgn),
            .sum   (sums[c*ACC_W +: ACC_W])
        );
    end

    wsmm_acc_bank #(.N(N), .ACC_W(ACC_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (v2),
        .wr_add  (mode_q.accum),
        .wr_addr (addr2),
        .wr_row  (s2),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no result is still in flight when done is raised
    a_r9_done_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pipe_empty);

    // R8: never more rows accepted than the command asked for
    a_r8_accept_bound: assert property (@(posedge clk) disable iff (!rst_n)
        x_fire |-> (in_cnt < rows_q));

    // R11: a zero-row start leaves the engine idle
    a_r11_zero_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && start_rows == '0) |=> (state == ST_IDLE));

    // R2: after done the engine is back to taking weights
    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> w_ready);

endmodule

// File: tb/sim_wsmm_engine.sv
module sim_wsmm_engine;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4, DEPTH = 16, CNT_W = 8, AW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic w_valid = 0, start = 0, start_accum = 0, start_xs = 0, start_ws = 0;
    logic x_valid = 0, rd_en = 0;
    logic [N*8-1:0] w_row = '0, x_row = '0;
    logic [AW-1:0] start_base = '0, rd_addr = '0;
    logic [CNT_W-1:0] start_rows = '0;
    logic w_ready, x_ready, done;
    logic [N*32-1:0] rd_data;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0]  w_m [N][N];
    logic [7:0]  xb  [64][N];
    logic [31:0] acc_m [DEPTH][N];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    wsmm_engine #(.N(N), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_ready(w_ready), .w_row(w_row),
        .start(start), .start_base(start_base), .start_rows(start_rows),
        .start_accum(start_accum), .start_x_signed(start_xs), .start_w_signed(start_ws),
        .x_valid(x_valid), .x_ready(x_ready), .x_row(x_row), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic chk(input string tag, input logic [N*32-1:0] act, input logic [N*32-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int ext(input logic [7:0] v, input bit s);
        return s ? int'($signed(v)) : int'(v);
    endfunction

    function automatic logic [N*32-1:0] model_row(input int a);
        logic [N*32-1:0] r;
        for (int c = 0; c < N; c++) r[c*32 +: 32] = acc_m[a][c];
        return r;
    endfunction

    task automatic read_row(input int a, output logic [N*32-1:0] d);
        @(negedge clk); rd_en = 1; rd_addr = AW'(a);
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic load_weights();
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            w_valid = 1;
            for (int c = 0; c < N; c++) w_row[c*8 +: 8] = w_m[j][c];
            chk("R1 w_ready idle", N*32'(w_ready), N*32'(1));
        end
        @(negedge clk); w_valid = 0;
    endtask

    // runs one operation; gaps: stall pattern, busy_poke: offer weights and a start mid-run
    task automatic run_op(input int base, input int rows, input bit acc, input bit xs,
                          input bit ws, input bit gaps, input bit busy_poke, input string tag);
        int idx, t0, tdone, k;
        bit fire;
        logic [N*32-1:0] d;
        @(negedge clk);
        start = 1; start_base = AW'(base); start_rows = CNT_W'(rows);
        start_accum = acc; start_xs = xs; start_ws = ws;
        @(negedge clk);
        start = 0; t0 = cyc;
        idx = 0; k = 0;
        while (idx < rows) begin
            x_valid = gaps ? ((k % 3) != 1) : 1'b1;
            for (int j = 0; j < N; j++) x_row[j*8 +: 8] = xb[idx][j];
            if (busy_poke && k == 1) begin
                w_valid = 1; w_row = '1; start = 1; start_base = 4'd9; start_rows = 8'd1;
                #1;
                chk("R2 w_ready low while busy", N*32'(w_ready), '0);
            end
            if (!gaps) chk({tag, " R7 x_ready streaming"}, N*32'(x_ready), N*32'(1));
            fire = x_valid && x_ready;
            @(negedge clk);
            w_valid = 0; start = 0;
            if (fire) idx++;
            k++;
            if (k > 200) break;
        end
        x_valid = 0;
        if (!gaps) chk({tag, " R7 x_ready closes after B"}, N*32'(x_ready), '0);
        tdone = -1;
        for (int i = 0; i < 20 && tdone < 0; i++) begin
            if (done) tdone = cyc; else @(negedge clk);
        end
        if (!gaps) chk({tag, " R7 done latency"}, N*32'(tdone - t0), N*32'(rows + 3));
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, N*32'(done), '0);
        for (int r = 0; r < rows; r++) begin
            int a = (base + r) % DEPTH;
            for (int c = 0; c < N; c++) begin
                int s = 0;
                for (int j = 0; j < N; j++) s += ext(xb[r][j], xs) * ext(w_m[j][c], ws);
                acc_m[a][c] = acc ? acc_m[a][c] + 32'(s) : 32'(s);
            end
        end
        for (int r = 0; r < rows; r++) begin
            int a = (base + r) % DEPTH;
            read_row(a, d);
            chk({tag, " R3 R6 result row"}, d, model_row(a));
        end
    endtask

    task automatic t_reset();
        logic [N*32-1:0] d;
        chk("R12 w_ready after reset", N*32'(w_ready), N*32'(1));
        chk("R12 x_ready after reset", N*32'(x_ready), '0);
        chk("R12 done after reset", N*32'(done), '0);
        read_row(3, d);
        chk("R12 acc row zero", d, '0);
    endtask

    task automatic t_basic();
        for (int j = 0; j < N; j++) for (int c = 0; c < N; c++) w_m[j][c] = 8'(j*53 + c*29 + 5);
        for (int r = 0; r < 8; r++) for (int j = 0; j < N; j++) xb[r][j] = 8'(r*37 + j*11 + 3);
        load_weights();
        run_op(2, 3, 0, 0, 0, 0, 0, "R1 unsigned");
    endtask

    task automatic t_signed();
        for (int r = 0; r < 8; r++) for (int j = 0; j < N; j++) xb[r][j] = 8'(r*71 + j*97 + 130);
        run_op(14, 4, 0, 1, 1, 0, 0, "R4 signed wrap addr");
        run_op(14, 4, 1, 1, 0, 0, 0, "R5 R4 mixed accumulate");
    endtask

    task automatic t_wrap32();
        logic [N*32-1:0] d;
        for (int j = 0; j < N; j++) for (int c = 0; c < N; c++) w_m[j][c] = (j == c) ? 8'd1 : 8'd0;
        load_weights();
        xb[0][0] = 10; xb[0][1] = 20; xb[0][2] = 30; xb[0][3] = 40;
        run_op(5, 1, 0, 0, 0, 0, 0, "R5 overwrite");
        xb[0][0] = 8'h80; xb[0][1] = 8'hFF; xb[0][2] = 8'h00; xb[0][3] = 8'h7F;
        run_op(5, 1, 1, 1, 1, 0, 0, "R5 accumulate");
        read_row(5, d);
        chk("R5 wrap below zero", d, {32'd167, 32'd30, 32'd19, 32'hFFFFFF8A});
    endtask

    task automatic t_stall();
        for (int j = 0; j < N; j++) for (int c = 0; c < N; c++) w_m[j][c] = 8'(j*19 + c*83 + 200);
        for (int r = 0; r < 8; r++) for (int j = 0; j < N; j++) xb[r][j] = 8'(r*13 + j*149 + 7);
        load_weights();
        run_op(8, 6, 0, 1, 1, 1, 0, "R8 stalled stream");
    endtask

    task automatic t_busy();
        logic [N*32-1:0] d;
        run_op(0, 5, 0, 0, 1, 0, 1, "R2 R11 busy pokes");
        repeat (6) begin
            @(negedge clk);
            chk("R11 no second done", N*32'(done), '0);
        end
        read_row(9, d);
        chk("R11 ignored start wrote nothing", d, model_row(9));
        run_op(0, 2, 0, 0, 1, 0, 0, "R2 weights kept");
    endtask

    task automatic t_zero_rows();
        @(negedge clk); start = 1; start_rows = 0; start_base = 4'd3;
        @(negedge clk); start = 0;
        chk("R11 zero rows stays idle", N*32'(w_ready), N*32'(1));
        repeat (5) begin
            @(negedge clk);
            chk("R11 zero rows no done", N*32'(done | x_ready), '0);
        end
    endtask

    task automatic t_read_hold();
        logic [N*32-1:0] d;
        read_row(8, d);
        repeat (3) @(negedge clk);
        chk("R10 rd_data holds", rd_data, d);
        chk("R10 rd_data value", d, model_row(8));
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) for (int c = 0; c < N; c++) acc_m[a][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_signed();
        t_wrap32();
        t_stall();
        t_busy();
        t_zero_rows();
        t_read_hold();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule